// File: doc/BRIEF.md
# Two-Channel Mixer and PWM Modulator

This block mixes two unsigned 7-bit audio channel samples into one 8-bit value and turns that value into a one-bit pulse-width modulated output for an external low-pass filter. All of its timing comes from a free-running 10-bit subsample phase that it shares with the waveform generators. One full phase cycle of 1024 clocks is one audio sample period. That period holds four PWM periods of 256 clocks each, so the PWM frequency is the clock divided by 256.

The sum of the two channels is taken once per sample period, on the clock edge where the phase is zero, and held for the whole period. All four pulses of a sample therefore carry the same duty. The output is a flip-flop driven by a compare of the low eight phase bits against the held sample. An internal reset synchronizer asserts the reset at once and releases it in step with the clock.

Top module: `dual_pwm_mixer`

## Requirements
- R1: The mixed sample is the unsigned 8-bit sum of the two 7-bit channel inputs. The largest value is 127 + 127 = 254, and it never wraps.
- R2: The held sample loads only on a clock edge at which the 10-bit phase input equals 0. Channel changes while the phase is not 0 have no effect on the output.
- R3: The output is registered. After a clock edge that samples phase value p, the output is 1 exactly when p[7:0] is less than the sample in effect. At the loading edge (p = 0), the sample in effect is the newly loaded one.
- R4: Each sample period of 1024 clocks holds four 256-clock PWM periods. In each of them the output is high for exactly S clocks, where S is the held sample, and those clocks come first.
- R5: A sample of 0 keeps the output low for the whole sample period.
- R6: A sample of 254 gives 254 high clocks and 2 low clocks in every 256-clock PWM period.
- R7: While reset is asserted the output is low and the held sample is 0. After reset, the output stays low until the first edge with phase 0 loads a sample.
- R8: Phase bits [9:8] do not affect the compare. Only phase[7:0] is compared, so the same low bits give the same output in any quarter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, 256 times the PWM rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_phase | input | 10 | Shared subsample phase counter |
| chan_a | input | 7 | First channel sample, unsigned |
| chan_b | input | 7 | Second channel sample, unsigned |
| pwm_out | output | 1 | Registered PWM audio output |

## Verification
On every cycle the assertions check four things: the load of the channel sum at phase zero, that the held sample stays stable at every other phase, that the registered output matches the compare of the previous phase against the sample in effect, and that a zero sample keeps the output low. Some behaviour shows only over a whole period, so only the bench scenarios can confirm it. This covers the exact count of high clocks in each of the four quarter periods, the two low clocks at the largest sum, and the silent output between reset and the first phase-zero load. The bench also shows that channel inputs which change in the middle of a period leave the duty unchanged.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  parameter int CH_W  = 7;
  parameter int PH_W  = 10;
  parameter int MIX_W = CH_W + 1;
  typedef logic [MIX_W-1:0] mix_t;
endpackage

// File: rtl/dpm_rst_sync.sv
module dpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dpm_adder.sv
module dpm_adder #(
  parameter int CH_W = 7,
  localparam int SUM_W = CH_W + 1
) (
  input  logic [CH_W-1:0]  in_a,
  input  logic [CH_W-1:0]  in_b,
  output logic [SUM_W-1:0] sum
);
  always_comb sum = {1'b0, in_a} + {1'b0, in_b};
endmodule

// File: rtl/dpm_sample_reg.sv
module dpm_sample_reg #(
  parameter int W    = 8,
  parameter int PH_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase,
  input  logic [W-1:0]    mix_in,
  output logic [W-1:0]    level_q,
  output logic [W-1:0]    level_nxt
);
  logic load_en;

  always_comb begin
    load_en   = (phase == '0);
    level_nxt = load_en ? mix_in : level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_nxt;
  end
endmodule

// File: rtl/dpm_pwm_cmp.sv
module dpm_pwm_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic [W-1:0] level,
  output logic         pwm_q
);
  logic pwm_d;

  always_comb pwm_d = (count < level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end
endmodule

// File: rtl/dual_pwm_mixer.sv
module dual_pwm_mixer
  import dpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] sub_phase,
  input  logic [CH_W-1:0] chan_a,
  input  logic [CH_W-1:0] chan_b,
  output logic            pwm_out
);
  localparam int CNT_W = MIX_W;

  logic rst_sync_n;
  mix_t mix_sum;
  mix_t level_q;
  mix_t level_nxt;

  dpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dpm_adder #(.CH_W(CH_W)) u_add (
    .in_a (chan_a),
    .in_b (chan_b),
    .sum  (mix_sum)
  );

  dpm_sample_reg #(.W(MIX_W), .PH_W(PH_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase     (sub_phase),
    .mix_in    (mix_sum),
    .level_q   (level_q),
    .level_nxt (level_nxt)
  );

  dpm_pwm_cmp #(.W(MIX_W)) u_cmp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .count (sub_phase[CNT_W-1:0]),
    .level (level_nxt),
    .pwm_q (pwm_out)
  );
endmodule

// File: rtl/dual_pwm_mixer_chk.sv
module dual_pwm_mixer_chk
  import dpm_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic [PH_W-1:0] sub_phase,
  input logic [CH_W-1:0] chan_a,
  input logic [CH_W-1:0] chan_b,
  input logic [MIX_W-1:0] level_q,
  input logic            pwm_out
);
  // R1: the loaded level is the widened channel sum
  assert_load_sum_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sub_phase == '0) |=> (level_q == ({1'b0, $past(chan_a)} + {1'b0, $past(chan_b)})));

  // R2: no load away from phase zero
  assert_hold_level_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sub_phase != '0) |=> $stable(level_q));

  // R3 / R8: registered output follows the low phase bits against the level in effect
  assert_pwm_compare_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (pwm_out == ($past(sub_phase[MIX_W-1:0]) < level_q)));

  // R5: a zero level keeps the output low
  assert_zero_silent_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (level_q == '0) |-> !pwm_out);

  // R7: reset state
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      assert_reset_low_R7: assert (!pwm_out && level_q == '0);
    end
  end
endmodule

bind dual_pwm_mixer dual_pwm_mixer_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sub_phase  (sub_phase),
  .chan_a     (chan_a),
  .chan_b     (chan_b),
  .level_q    (level_q),
  .pwm_out    (pwm_out)
);

// File: tb/dual_pwm_mixer_test.sv
`timescale 1ns/1ps
module dual_pwm_mixer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] sub_phase;
  logic [6:0] chan_a;
  logic [6:0] chan_b;
  logic       pwm_out;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_pwm_mixer uut (
    .clk(clk), .rst_n(rst_n), .sub_phase(sub_phase),
    .chan_a(chan_a), .chan_b(chan_b), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive phase p and channels at a negedge, sample the output at the next negedge
  task automatic step(input int p, output bit o);
    sub_phase = p[9:0];
    @(posedge clk);
    @(negedge clk);
    o = pwm_out;
  endtask

  // one full sample period; channels optionally disturbed after phase zero
  task automatic t_sample(input int a, input int b, input bit disturb, input string req);
    int s = a + b;
    bit o;
    chan_a = a[6:0];
    chan_b = b[6:0];
    for (int q = 0; q < 4; q++) begin
      int hi = 0;
      int bad = 0;
      for (int k = 0; k < 256; k++) begin
        step(q * 256 + k, o);
        if (disturb) begin
          chan_a = 7'((k * 37 + q) & 127);
          chan_b = 7'((k * 91 + 5) & 127);
        end
        if (o) hi++;
        if (o != (k < s)) bad++;
      end
      check(hi == s, req, hi, s);
      check(bad == 0, {req, " pattern"}, bad, 0);
    end
  endtask

  task automatic t_reset();
    bit o;
    rst_n = 1'b0;
    sub_phase = 10'd0;
    chan_a = 7'd127;
    chan_b = 7'd127;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pwm_out == 1'b0, "R7 in reset", pwm_out, 0);
    rst_n = 1'b1;
    sub_phase = 10'd7;
    repeat (4) @(negedge clk);
    begin
      int hi = 0;
      for (int p = 8; p < 400; p++) begin
        step(p, o);
        if (o) hi++;
      end
      check(hi == 0, "R7 silent before first load", hi, 0);
    end
  endtask

  // phase upper bits vary out of order; only low bits matter
  task automatic t_upper();
    bit o;
    int bad = 0;
    int s = 60 + 40;
    chan_a = 7'd60;
    chan_b = 7'd40;
    step(0, o);
    for (int k = 1; k < 200; k++) begin
      int p = (((k * 3) % 4) << 8) | ((k * 7) & 255);
      if (p == 0) p = 1;
      step(p, o);
      if (o != ((p & 255) < s)) bad++;
    end
    check(bad == 0, "R8 upper phase bits ignored", bad, 0);
  endtask

  initial begin
    t_reset();
    t_sample(10, 20, 0, "R4 sum 30");
    t_sample(0, 0, 0, "R5 zero sample");
    t_sample(127, 127, 0, "R6 R1 max 254");
    t_sample(100, 3, 1, "R2 hold despite channel changes");
    t_sample(127, 0, 0, "R1 one-sided 127");
    t_sample(1, 0, 0, "R3 single high clock");
    t_upper();
    t_sample(64, 64, 0, "R3 R4 mid 128");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule